// File: doc/BRIEF.md
# Double-Buffered Serial Divider Configuration Port

This block is the control front end of an integer-N frequency synthesizer. A host loads it through three serial wires: data, a serial clock and an active-low load strobe. A fourth wire chooses where the bits go. With the route pin low, a 20-bit word goes into the primary register. With it high, an 8-bit control byte goes into the auxiliary shift register. All pins are asynchronous to the block clock. Each pin passes through a two-flop synchronizer and an edge detector, so every register sits in the single system clock domain.

A rising edge on the load strobe copies the primary register into the secondary register. A bank-select pin decides which of the two words drives the decoded divider fields. This lets the host hold two settings and switch between them with one pin. The auxiliary byte moves into a holding buffer on the falling edge of the route pin. Its control bits reach the outputs only while the active-low auxiliary-enable pin is low. Otherwise those outputs are forced to zero.

A three-state machine in the controller tracks the link. ST_IDLE means the strobe is high and nothing shifts. ST_MAIN means the strobe is low with the route pin low, and serial clock edges shift into the primary register. ST_AUX means the strobe is low with the route pin high, and serial clock edges shift into the auxiliary register. The machine has these transitions:

- IDLE_TO_MAIN: the strobe falls while the route pin is low.
- IDLE_TO_AUX: the strobe falls while the route pin is high.
- MAIN_TO_AUX: the route pin rises while the strobe is low.
- AUX_TO_MAIN: the route pin falls while the strobe is low.
- ANY_TO_IDLE: the strobe goes high.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset the primary, secondary and holding registers are zero, so every output reads zero.
- R2: While the strobe is low and the route pin is low, each serial clock rising edge shifts one data bit into the primary register. The first bit sent lands in word bit 19 after 20 edges. The decode is as follows. Word bits 19 and 18 are ref_div bits 5 and 4. Word bits 7 to 4 are ref_div bits 3 to 0. Word bits 17 and 16 are main_div bits 8 and 7. Word bits 14 to 8 are main_div bits 6 to 0. Word bit 15 is prescaler_bypass. Word bits 3 to 0 are swallow_cnt.
- R3: A rising edge of the load strobe copies the primary word into the secondary word.
- R4: With bank_sel high the decoded fields come from the primary word. With bank_sel low they come from the secondary word.
- R5: Serial clock edges while the strobe is high change no register.
- R6: Shifting into the auxiliary register leaves the primary word unchanged.
- R7: The auxiliary holding buffer changes only on a falling edge of the route pin. It then takes the 8 bits last shifted, with the first bit sent as bit 0.
- R8: While aux_en_n is low, the outputs map from the held byte as follows: bit 2 is dbg_main, bit 3 is power_down, bit 4 is counter_load, bit 5 is dbg_modsel and bit 6 is dbg_ref. Bits 0, 1 and 7 drive nothing. While aux_en_n is high, all five outputs are zero.
- R9: A strobe rise and a route-pin fall that arrive in the same cycle both take effect.
- R10: The secondary word does not change between strobe rises, whatever is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, sampled on its rising edge |
| ser_data | input | 1 | Serial data, first bit is the most significant |
| load_n | input | 1 | Load strobe; shifting is allowed while low, and a rise copies primary to secondary |
| route_aux | input | 1 | Route pin; high selects the auxiliary register, and a fall captures the byte |
| bank_sel | input | 1 | 1 selects the primary word, 0 selects the secondary word |
| aux_en_n | input | 1 | Active-low enable for the auxiliary control outputs |
| ref_div | output | 6 | Reference divider field |
| main_div | output | 9 | Main divider field |
| swallow_cnt | output | 4 | Swallow counter field |
| prescaler_bypass | output | 1 | Prescaler bypass field |
| dbg_main | output | 1 | Route main divider output to the debug pin |
| power_down | output | 1 | Power-down control |
| counter_load | output | 1 | Continuous counter load control |
| dbg_modsel | output | 1 | Route modulus select to the debug pin |
| dbg_ref | output | 1 | Route reference divider output to the debug pin |

## Verification
Two functions can collide in one cycle: the strobe-rise transfer of the primary word and the route-fall capture of the auxiliary byte. The bench provokes this by shifting a byte in ST_AUX and then moving load_n high and route_aux low in the same time step. Both pins pass through identical synchronizers, so their edges are detected together. The scoreboard then expects two results at once: the secondary bank shows the new word, and the control outputs show the new byte.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int MAIN_W      = 20;
    localparam int AUX_W       = 8;
    localparam int REF_W       = 6;
    localparam int MDIV_W      = 9;
    localparam int SWAL_W      = 4;
    localparam int SYNC_STAGES = 2;

    // bit positions inside the held auxiliary byte (index n = n-th bit sent)
    localparam int AUX_DBG_MAIN = 2;
    localparam int AUX_PWR_DN   = 3;
    localparam int AUX_CNT_LD   = 4;
    localparam int AUX_DBG_MOD  = 5;
    localparam int AUX_DBG_REF  = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAIN = 2'd1,
        ST_AUX  = 2'd2
    } port_state_e;

    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic [MDIV_W-1:0] main_div;
        logic [SWAL_W-1:0] swallow;
        logic              bypass;
    } div_cfg_t;

    typedef struct packed {
        logic dbg_main;
        logic power_down;
        logic counter_load;
        logic dbg_modsel;
        logic dbg_ref;
    } aux_ctl_t;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int N      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                    prev  <= 1'b0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_i[g]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign level_o[g] = chain[STAGES-1];
            assign rise_o[g]  = chain[STAGES-1] & ~prev;
            assign fall_o[g]  = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/cfg_shift_ctrl.sv
module cfg_shift_ctrl
    import cfg_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_lvl,
    input  logic        route_lvl,
    input  logic        load_rise,
    input  logic        route_fall,
    input  logic        sclk_rise,
    output logic        shift_main,
    output logic        shift_aux,
    output logic        xfer,
    output logic        capture,
    output port_state_e state_o
);
    port_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!load_lvl)
                    state_d = route_lvl ? ST_AUX : ST_MAIN;
            end
            ST_MAIN: begin
                if (load_lvl)       state_d = ST_IDLE;
                else if (route_lvl) state_d = ST_AUX;
            end
            ST_AUX: begin
                if (load_lvl)        state_d = ST_IDLE;
                else if (!route_lvl) state_d = ST_MAIN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        shift_main = 1'b0;
        shift_aux  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MAIN: shift_main = sclk_rise;
            ST_AUX:  shift_aux  = sclk_rise;
            default: ;
        endcase
        xfer    = load_rise;
        capture = route_fall;
    end

    assign state_o = state_q;
endmodule

// File: rtl/cfg_main_bank.sv
module cfg_main_bank
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              data_bit,
    input  logic              xfer,
    input  logic              bank_sel,
    output logic [MAIN_W-1:0] prim_o,
    output logic [MAIN_W-1:0] sec_o,
    output div_cfg_t          cfg_o
);
    logic [MAIN_W-1:0] prim_q, sec_q, word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prim_q <= '0;
            sec_q  <= '0;
        end else begin
            if (shift_en) prim_q <= {prim_q[MAIN_W-2:0], data_bit};
            if (xfer)     sec_q  <= prim_q;
        end
    end

    assign word = bank_sel ? prim_q : sec_q;

    // field decode; positions fixed by the serial bit order
    always_comb begin
        cfg_o.ref_div  = {word[19:18], word[7:4]};
        cfg_o.main_div = {word[17:16], word[14:8]};
        cfg_o.bypass   = word[15];
        cfg_o.swallow  = word[3:0];
    end

    assign prim_o = prim_q;
    assign sec_o  = sec_q;
endmodule

// File: rtl/cfg_aux_bank.sv
module cfg_aux_bank
    import cfg_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             data_bit,
    input  logic             capture,
    input  logic             enable,
    output logic [AUX_W-1:0] hold_o,
    output aux_ctl_t         ctl_o
);
    logic [AUX_W-1:0] shreg_q, hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            hold_q  <= '0;
        end else begin
            if (shift_en) shreg_q <= {data_bit, shreg_q[AUX_W-1:1]};
            if (capture)  hold_q  <= shreg_q;
        end
    end

    always_comb begin
        ctl_o = '0;
        if (enable) begin
            ctl_o.dbg_main     = hold_q[AUX_DBG_MAIN];
            ctl_o.power_down   = hold_q[AUX_PWR_DN];
            ctl_o.counter_load = hold_q[AUX_CNT_LD];
            ctl_o.dbg_modsel   = hold_q[AUX_DBG_MOD];
            ctl_o.dbg_ref      = hold_q[AUX_DBG_REF];
        end
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              load_n,
    input  logic              route_aux,
    input  logic              bank_sel,
    input  logic              aux_en_n,
    output logic [REF_W-1:0]  ref_div,
    output logic [MDIV_W-1:0] main_div,
    output logic [SWAL_W-1:0] swallow_cnt,
    output logic              prescaler_bypass,
    output logic              dbg_main,
    output logic              power_down,
    output logic              counter_load,
    output logic              dbg_modsel,
    output logic              dbg_ref
);
    localparam int NPIN = 6;
    localparam int P_SCLK = 0, P_DATA = 1, P_LOAD = 2, P_ROUTE = 3, P_BANK = 4, P_AEN = 5;

    logic [NPIN-1:0] pins, lvl, rise, fall;
    logic            shift_main, shift_aux, xfer, capture, aux_off;
    port_state_e     state;
    logic [MAIN_W-1:0] prim_word, sec_word;
    logic [AUX_W-1:0]  aux_hold;
    div_cfg_t          cfg;
    aux_ctl_t          ctl;

    assign pins = {aux_en_n, bank_sel, route_aux, load_n, ser_data, ser_clk};

    cfg_sync_edge #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pins),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    cfg_shift_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .load_lvl(lvl[P_LOAD]), .route_lvl(lvl[P_ROUTE]),
        .load_rise(rise[P_LOAD]), .route_fall(fall[P_ROUTE]),
        .sclk_rise(rise[P_SCLK]),
        .shift_main(shift_main), .shift_aux(shift_aux),
        .xfer(xfer), .capture(capture), .state_o(state)
    );

    cfg_main_bank u_main (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_main), .data_bit(lvl[P_DATA]),
        .xfer(xfer), .bank_sel(lvl[P_BANK]),
        .prim_o(prim_word), .sec_o(sec_word), .cfg_o(cfg)
    );

    assign aux_off = lvl[P_AEN];

    cfg_aux_bank u_aux (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_aux), .data_bit(lvl[P_DATA]),
        .capture(capture), .enable(~aux_off),
        .hold_o(aux_hold), .ctl_o(ctl)
    );

    assign ref_div          = cfg.ref_div;
    assign main_div         = cfg.main_div;
    assign swallow_cnt      = cfg.swallow;
    assign prescaler_bypass = cfg.bypass;
    assign dbg_main         = ctl.dbg_main;
    assign power_down       = ctl.power_down;
    assign counter_load     = ctl.counter_load;
    assign dbg_modsel       = ctl.dbg_modsel;
    assign dbg_ref          = ctl.dbg_ref;
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk
    import cfg_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input port_state_e       state,
    input logic              xfer,
    input logic              capture,
    input logic              aux_off,
    input logic [MAIN_W-1:0] prim_word,
    input logic [MAIN_W-1:0] sec_word,
    input logic [AUX_W-1:0]  aux_hold,
    input logic              dbg_main,
    input logic              power_down,
    input logic              counter_load,
    input logic              dbg_modsel,
    input logic              dbg_ref
);
    assert_xfer_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> sec_word == $past(prim_word));

    assert_sec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(sec_word));

    assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |=> $stable(prim_word));

    assert_aux_keeps_prim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_AUX |=> $stable(prim_word));

    assert_hold_only_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(aux_hold));

    assert_aux_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        aux_off |-> !(dbg_main | power_down | counter_load | dbg_modsel | dbg_ref));
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .xfer(xfer), .capture(capture),
    .aux_off(aux_off), .prim_word(prim_word), .sec_word(sec_word),
    .aux_hold(aux_hold), .dbg_main(dbg_main), .power_down(power_down),
    .counter_load(counter_load), .dbg_modsel(dbg_modsel), .dbg_ref(dbg_ref)
);

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 0, ser_data = 0, load_n = 1, route_aux = 0, bank_sel = 1, aux_en_n = 1;
    logic [5:0] ref_div;
    logic [8:0] main_div;
    logic [3:0] swallow_cnt;
    logic prescaler_bypass, dbg_main, power_down, counter_load, dbg_modsel, dbg_ref;

    int total = 0, bad = 0;
    bit done = 0;

    logic [24:0] exp_q[$];
    string       tag_q[$];

    // bench model
    logic [19:0] m_prim = '0, m_sec = '0;
    logic [7:0]  m_shift = '0, m_hold = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .load_n(load_n), .route_aux(route_aux), .bank_sel(bank_sel), .aux_en_n(aux_en_n),
        .ref_div(ref_div), .main_div(main_div), .swallow_cnt(swallow_cnt),
        .prescaler_bypass(prescaler_bypass), .dbg_main(dbg_main), .power_down(power_down),
        .counter_load(counter_load), .dbg_modsel(dbg_modsel), .dbg_ref(dbg_ref)
    );

    function automatic logic [19:0] pack_word(logic [5:0] r, logic [8:0] m, logic [3:0] a, logic b);
        return {r[5], r[4], m[8], m[7], b, m[6:0], r[3:0], a};
    endfunction

    function automatic logic [24:0] expect_vec();
        logic [19:0] w;
        logic [4:0]  c;
        w = bank_sel ? m_prim : m_sec;
        c = aux_en_n ? 5'b0 : {m_hold[2], m_hold[3], m_hold[4], m_hold[5], m_hold[6]};
        return {w[19:18], w[7:4], w[17:16], w[14:8], w[3:0], w[15], c};
    endfunction

    task automatic wait_gap();
        repeat (GAP) @(posedge clk);
    endtask

    task automatic pulse_bit(logic b);
        ser_data = b; wait_gap();
        ser_clk = 1;  wait_gap();
        ser_clk = 0;  wait_gap();
    endtask

    task automatic send_main(logic [19:0] w);
        for (int i = 19; i >= 0; i--) pulse_bit(w[i]);
        m_prim = w;
    endtask

    task automatic send_aux(logic [7:0] b);
        for (int i = 0; i < 8; i++) pulse_bit(b[i]);
        m_shift = b;
    endtask

    // driver side of the scoreboard
    task automatic expect_now(string tag);
        wait_gap();
        @(posedge clk);
        exp_q.push_back(expect_vec());
        tag_q.push_back(tag);
        @(posedge clk);
        @(posedge clk);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [24:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {ref_div, main_div, swallow_cnt, prescaler_bypass,
                 dbg_main, power_down, counter_load, dbg_modsel, dbg_ref};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] w1, w2;
        w1 = pack_word(6'h2A, 9'h15B, 4'h9, 1'b1);
        w2 = pack_word(6'h05, 9'h0A3, 4'h3, 1'b0);
        repeat (3) @(posedge clk);
        rst_n = 1;
        wait_gap();
        expect_now("R1 reset bank1");
        bank_sel = 0; aux_en_n = 0;
        expect_now("R1 reset bank0 aux on");
        aux_en_n = 1; bank_sel = 1;

        // R2: shift a word, primary visible
        load_n = 0; wait_gap();
        send_main(w1);
        expect_now("R2 primary decode");
        bank_sel = 0;
        expect_now("R10 secondary before strobe");
        // R3: strobe rise copies
        load_n = 1; m_sec = m_prim;
        expect_now("R3 copy on strobe rise");
        // R5: clocks with strobe high ignored
        bank_sel = 1;
        for (int k = 0; k < 5; k++) pulse_bit(1'b1);
        expect_now("R5 clocks ignored while strobe high");

        // R4 / R10: new word, ping-pong
        load_n = 0; wait_gap();
        send_main(w2);
        expect_now("R4 bank1 shows primary");
        bank_sel = 0;
        expect_now("R10 bank0 keeps old word");
        bank_sel = 1;

        // R6 / R7: shift aux byte without capture
        route_aux = 1; aux_en_n = 0; wait_gap();
        send_aux(8'b0101_0100);
        expect_now("R6 primary untouched by aux shift");
        expect_now("R7 no capture before route fall");
        route_aux = 0; m_hold = m_shift;
        expect_now("R8 aux bits 2 4 6 active");
        aux_en_n = 1;
        expect_now("R8 aux outputs gated off");
        aux_en_n = 0;

        // R9: strobe rise and route fall together
        route_aux = 1; wait_gap();
        send_aux(8'b0010_1000);
        bank_sel = 0;
        load_n = 1; route_aux = 0;
        m_sec = m_prim; m_hold = m_shift;
        expect_now("R9 simultaneous copy and capture");

        // boundary: all ones word
        load_n = 0; wait_gap();
        send_main(20'hFFFFF);
        load_n = 1; m_sec = m_prim;
        expect_now("R2 all ones bank0");
        bank_sel = 1;
        expect_now("R4 all ones bank1");

        wait_gap();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule